// File: doc/BRIEF.md
# Key-Combination Reset Pulse Generator

This block produces a system reset pulse when the user holds a programmed combination of keys or general inputs. Scan logic elsewhere on the chip supplies a decoded vector of flags, one flag per 8-bit event code, and each flag is high while its event is held. Up to three code slots name the events that make up the combination. Once every programmed slot has been held together for the selected time, the block drives one active-low pulse of the selected width on its reset line. A locked-up system can then be recovered without removing power.

A 4-bit field selects the hold time. It is counted in prescaled millisecond ticks, and one code triggers at once. A 2-bit field selects the pulse width. A pass-through mode replaces the generated pulse with the level of an external reset pin. A separate enable drives the pad's output-enable line.

Top module: `keycombo_reset`

## Requirements
- R1: After reset, and while no pulse is active and pass-through is off, `rst_pin_o` is high. The line is active low.
- R2: Each slot looks up `evt_held_i[code]`. A slot whose code is 0 is unused and counts as satisfied. A hold starts only when every non-zero slot's flag is high at the same time.
- R3: When all three codes are 0, no pulse is ever generated, whatever the flags are.
- R4: The hold time depends on `trig_sel_i`. Code 0 fires at once. Code k from 1 to 7 waits (k+1)·HALF_SEC_TICKS ticks. Codes 8 to 15 wait 8·HALF_SEC_TICKS ticks. One tick is CYC_PER_TICK clock cycles. `rst_pin_o` falls 3 + ticks·CYC_PER_TICK cycles after the combination first appears at the inputs.
- R5: If any programmed event drops before the hold time expires, the timer restarts from zero when the combination next appears.
- R6: One qualifying hold produces exactly one pulse, however long it lasts. A new pulse needs at least one event to be released first.
- R7: The pulse width depends on `width_sel_i`, which is latched when the pulse starts. Code 0 gives SHORT_CYC cycles. Codes 1, 2 and 3 give 1, 14 and 28 ticks.
- R8: While `passthru_en_i` is 1, `rst_pin_o` follows `ext_rst_ni`.
- R9: `rst_oe_o` equals `out_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_held_i | input | 256 | Held flag for each event code |
| evt_code_a_i | input | 8 | Slot A event code (0 = unused) |
| evt_code_b_i | input | 8 | Slot B event code (0 = unused) |
| evt_code_c_i | input | 8 | Slot C event code (0 = unused) |
| trig_sel_i | input | 4 | Hold-time select |
| width_sel_i | input | 2 | Pulse-width select |
| ext_rst_ni | input | 1 | External reset pin level |
| passthru_en_i | input | 1 | Route `ext_rst_ni` to the output |
| out_en_i | input | 1 | Pad output enable |
| rst_pin_o | output | 1 | Reset line, active low |
| rst_oe_o | output | 1 | Pad output-enable line |

## Verification
The combination logic is tried with one slot, with two slots, and with three slots where only two are held. These patterns separate "all programmed slots" from "any slot" and show that zero codes count as wildcards. A hold that is broken and then restarted is timed against the restart, which shows the timer clears instead of pausing. A hold that lasts well past the pulse is followed by a release and a re-press, which separates one-shot behaviour from repeated firing. Immediate, mid-range and saturated hold codes are checked against all four widths, and the all-zero configuration is checked with every flag held.

// File: rtl/keycombo_reset_pkg.sv
package keycombo_reset_pkg;
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned NUM_CODES = 2 ** CODE_W;
  localparam int unsigned NUM_SLOTS = 3;
  localparam int unsigned W1_TICKS  = 1;
  localparam int unsigned W2_TICKS  = 14;
  localparam int unsigned W3_TICKS  = 28;

  typedef enum logic [1:0] {HOLD_IDLE, HOLD_RUN, HOLD_DONE} hold_state_e;

  // Hold length in ticks for a trigger-time code
  function automatic int unsigned hold_ticks(logic [3:0] sel, int unsigned half);
    if (sel == 4'd0) return 0;
    if (sel[3])      return 8 * half;
    return (int'(sel) + 1) * half;
  endfunction
endpackage

// File: rtl/keycombo_reset_tick.sv
module keycombo_reset_tick #(
  parameter int unsigned DIV = 250_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (cnt_q == CW'(DIV - 1))  cnt_q <= '0;
    else                             cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = !clr_i && (cnt_q == CW'(DIV - 1));

  a_r4_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/keycombo_reset_match.sv
module keycombo_reset_match
  import keycombo_reset_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CODES-1:0] held_i,
  input  logic [CODE_W-1:0]    codes_i [NUM_SLOTS],
  output logic                 combo_o
);
  logic [NUM_SLOTS-1:0] slot_ok;
  logic [NUM_SLOTS-1:0] slot_used;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_used[s] = (codes_i[s] != '0);
    assign slot_ok[s]   = !slot_used[s] || held_i[codes_i[s]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) combo_o <= 1'b0;
    else         combo_o <= (|slot_used) && (&slot_ok);
  end
endmodule

// File: rtl/keycombo_reset_hold.sv
module keycombo_reset_hold
  import keycombo_reset_pkg::*;
#(
  parameter int unsigned CYC_PER_TICK   = 250_000,
  parameter int unsigned HALF_SEC_TICKS = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       combo_i,
  input  logic [3:0] trig_sel_i,
  output logic       fire_o
);
  localparam int unsigned MAX_TICKS = 8 * HALF_SEC_TICKS;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  hold_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             tick;

  assign lim = CNT_W'(hold_ticks(trig_sel_i, HALF_SEC_TICKS));

  // Prescaler restarts on each new hold so the window is exact
  keycombo_reset_tick #(.DIV(CYC_PER_TICK)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != HOLD_RUN),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HOLD_IDLE;
      cnt_q   <= '0;
      fire_o  <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      unique case (state_q)
        HOLD_IDLE: if (combo_i) begin
          cnt_q <= '0;
          if (lim == '0) begin
            fire_o  <= 1'b1;
            state_q <= HOLD_DONE;
          end else begin
            state_q <= HOLD_RUN;
          end
        end
        HOLD_RUN: begin
          if (!combo_i) begin
            state_q <= HOLD_IDLE;
          end else if (tick) begin
            if (cnt_q + CNT_W'(1) >= lim) begin
              fire_o  <= 1'b1;
              state_q <= HOLD_DONE;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        HOLD_DONE: if (!combo_i) state_q <= HOLD_IDLE;
        default:   state_q <= HOLD_IDLE;
      endcase
    end
  end

  a_r2_fire_needs_combo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(combo_i));
  a_r5_drop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HOLD_RUN && !combo_i) |=> (state_q == HOLD_IDLE));
  a_r6_single_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
endmodule

// File: rtl/keycombo_reset_pulse.sv
module keycombo_reset_pulse
  import keycombo_reset_pkg::*;
#(
  parameter int unsigned CYC_PER_TICK = 250_000,
  parameter int unsigned SHORT_CYC    = 125
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] width_sel_i,
  output logic       active_o
);
  localparam int unsigned TW = $clog2(W3_TICKS + 1);
  localparam int unsigned SW = (SHORT_CYC > 1) ? $clog2(SHORT_CYC) : 1;

  logic [1:0]    sel_q;
  logic [SW-1:0] scnt_q;
  logic [TW-1:0] tcnt_q;
  logic [TW-1:0] wlim;
  logic          tick;

  always_comb begin
    unique case (sel_q)
      2'd1:    wlim = TW'(W1_TICKS);
      2'd2:    wlim = TW'(W2_TICKS);
      default: wlim = TW'(W3_TICKS);
    endcase
  end

  keycombo_reset_tick #(.DIV(CYC_PER_TICK)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!active_o),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      sel_q    <= '0;
      scnt_q   <= '0;
      tcnt_q   <= '0;
    end else if (!active_o) begin
      if (start_i) begin
        active_o <= 1'b1;
        sel_q    <= width_sel_i;
        scnt_q   <= '0;
        tcnt_q   <= '0;
      end
    end else if (sel_q == 2'd0) begin
      if (scnt_q == SW'(SHORT_CYC - 1)) active_o <= 1'b0;
      else                              scnt_q   <= scnt_q + SW'(1);
    end else if (tick) begin
      if (tcnt_q == wlim - TW'(1)) active_o <= 1'b0;
      else                         tcnt_q   <= tcnt_q + TW'(1);
    end
  end

  a_r7_width_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && $past(active_o)) |-> $stable(sel_q));
endmodule

// File: rtl/keycombo_reset.sv
module keycombo_reset
  import keycombo_reset_pkg::*;
#(
  parameter int unsigned CYC_PER_TICK   = 250_000,
  parameter int unsigned HALF_SEC_TICKS = 500,
  parameter int unsigned SHORT_CYC      = 125
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CODES-1:0] evt_held_i,
  input  logic [CODE_W-1:0]    evt_code_a_i,
  input  logic [CODE_W-1:0]    evt_code_b_i,
  input  logic [CODE_W-1:0]    evt_code_c_i,
  input  logic [3:0]           trig_sel_i,
  input  logic [1:0]           width_sel_i,
  input  logic                 ext_rst_ni,
  input  logic                 passthru_en_i,
  input  logic                 out_en_i,
  output logic                 rst_pin_o,
  output logic                 rst_oe_o
);
  logic [CODE_W-1:0] codes [NUM_SLOTS];
  logic combo, fire, pulse_active;

  assign codes[0] = evt_code_a_i;
  assign codes[1] = evt_code_b_i;
  assign codes[2] = evt_code_c_i;

  keycombo_reset_match u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .held_i  (evt_held_i),
    .codes_i (codes),
    .combo_o (combo)
  );

  keycombo_reset_hold #(
    .CYC_PER_TICK   (CYC_PER_TICK),
    .HALF_SEC_TICKS (HALF_SEC_TICKS)
  ) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .combo_i    (combo),
    .trig_sel_i (trig_sel_i),
    .fire_o     (fire)
  );

  keycombo_reset_pulse #(
    .CYC_PER_TICK (CYC_PER_TICK),
    .SHORT_CYC    (SHORT_CYC)
  ) u_pulse (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (fire),
    .width_sel_i (width_sel_i),
    .active_o    (pulse_active)
  );

  assign rst_pin_o = passthru_en_i ? ext_rst_ni : !pulse_active;
  assign rst_oe_o  = out_en_i;
endmodule

// File: tb/tb_keycombo_reset.sv
module tb_keycombo_reset;
  localparam int DIV   = 4;
  localparam int HALF  = 5;
  localparam int SHORT = 3;

  typedef struct {
    int    start;
    int    width;
    string req;
  } pulse_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] held = '0;
  logic [7:0]   code_a = '0, code_b = '0, code_c = '0;
  logic [3:0]   trig = '0;
  logic [1:0]   wsel = '0;
  logic         ext_n = 1'b1, pass_en = 1'b0, oe_en = 1'b1;
  logic         pin, oe;

  int     cyc = 0;
  int     checks = 0;
  int     errors = 0;
  int     pulses = 0;
  int     low_start = 0;
  bit     mon_en = 1'b1;
  bit     prev = 1'b1;
  pulse_t exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  keycombo_reset #(
    .CYC_PER_TICK (DIV),
    .HALF_SEC_TICKS (HALF),
    .SHORT_CYC (SHORT)
  ) dut (
    .clk_i (clk), .rst_ni (rst_n), .evt_held_i (held),
    .evt_code_a_i (code_a), .evt_code_b_i (code_b), .evt_code_c_i (code_c),
    .trig_sel_i (trig), .width_sel_i (wsel), .ext_rst_ni (ext_n),
    .passthru_en_i (pass_en), .out_en_i (oe_en),
    .rst_pin_o (pin), .rst_oe_o (oe)
  );

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Driver side: expected start cycle from the hold-time mapping
  task automatic expect_pulse(int ticks, int width, string req);
    pulse_t p;
    p.start = cyc + 3 + ticks * DIV;
    p.width = width;
    p.req   = req;
    exp_q.push_back(p);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: measures each low pulse and compares with the queue head
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (prev && !pin) begin
        low_start = cyc;
        pulses++;
      end
      if (!prev && pin) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected pulse", low_start, -1);
        end else begin
          pulse_t p;
          p = exp_q.pop_front();
          check((low_start >= p.start - 1) && (low_start <= p.start + 1),
                {p.req, " start"}, low_start, p.start);
          check((cyc - low_start) == p.width, {p.req, " width"},
                cyc - low_start, p.width);
        end
      end
    end
    prev = pin;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    check(pin == 1'b1, "R1 idle high", pin, 1);
    check(oe == 1'b1, "R9 oe follows", oe, 1);

    // R4 immediate, R7 short width, single slot
    code_a = 8'h11; trig = 4'd0; wsel = 2'd0;
    held[8'h11] = 1'b1; expect_pulse(0, SHORT, "R4/R7 immediate short");
    wait_cyc(20); held = '0; wait_cyc(10);

    // R2 two slots, R4 code 1, R7 one tick
    code_a = 8'h21; code_b = 8'h42; trig = 4'd1; wsel = 2'd1;
    held[8'h21] = 1'b1; held[8'h42] = 1'b1;
    expect_pulse(2 * HALF, W1(), "R2/R4 two slots");
    wait_cyc(80); held = '0; wait_cyc(10);

    // R2 three slots, only two held
    code_a = 8'h05; code_b = 8'h06; code_c = 8'h07; trig = 4'd3; wsel = 2'd2;
    n0 = pulses;
    held[8'h05] = 1'b1; held[8'h06] = 1'b1;
    wait_cyc(200);
    check(pulses == n0, "R2 partial combo no pulse", pulses - n0, 0);
    held[8'h07] = 1'b1; expect_pulse(4 * HALF, 14 * DIV, "R2/R7 three slots");
    wait_cyc(400);
    check(pulses == n0 + 1, "R6 one pulse per hold", pulses - n0, 1);
    held[8'h07] = 1'b0; wait_cyc(5);
    held[8'h07] = 1'b1; expect_pulse(4 * HALF, 14 * DIV, "R6 rearm");
    wait_cyc(200); held = '0; wait_cyc(10);

    // R5 drop mid-hold restarts the timer
    held[8'h05] = 1'b1; held[8'h06] = 1'b1; held[8'h07] = 1'b1;
    wait_cyc(50); held[8'h06] = 1'b0; wait_cyc(2);
    held[8'h06] = 1'b1; expect_pulse(4 * HALF, 14 * DIV, "R5 restart");
    wait_cyc(200); held = '0; wait_cyc(10);

    // R4 saturated code, R7 longest width
    code_a = 8'h80; code_b = '0; code_c = '0; trig = 4'd12; wsel = 2'd3;
    held[8'h80] = 1'b1; expect_pulse(8 * HALF, 28 * DIV, "R4 saturate/R7 long");
    wait_cyc(320); held = '0; wait_cyc(10);

    // R4 mid code 5, width latched (R7) despite a change mid-pulse
    trig = 4'd5; wsel = 2'd1;
    held[8'h80] = 1'b1; expect_pulse(6 * HALF, W1(), "R4 code5/R7 latch");
    wait_cyc(6 * HALF * DIV + 3); wsel = 2'd3;
    wait_cyc(40); held = '0; wait_cyc(10);

    // R3 all slots unused
    code_a = '0; trig = 4'd0; n0 = pulses;
    held = '1; wait_cyc(100);
    check(pulses == n0, "R3 no slots no pulse", pulses - n0, 0);
    check(pin == 1'b1, "R3 pin high", pin, 1);
    held = '0; wait_cyc(5);

    // R8 pass-through
    mon_en = 1'b0; pass_en = 1'b1; ext_n = 1'b0; wait_cyc(1);
    check(pin == 1'b0, "R8 passthru low", pin, 0);
    ext_n = 1'b1; wait_cyc(1);
    check(pin == 1'b1, "R8 passthru high", pin, 1);
    pass_en = 1'b0;

    // R9 output enable
    oe_en = 1'b0; wait_cyc(1);
    check(oe == 1'b0, "R9 oe off", oe, 0);
    oe_en = 1'b1; wait_cyc(1);
    check(oe == 1'b1, "R9 oe on", oe, 1);

    check(exp_q.size() == 0, "R6 all expected pulses seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int W1();
    return DIV;
  endfunction
endmodule